// File: doc/BRIEF.md
# AUX Transaction Completion Classifier

This block sits beside an AUX channel controller and watches its interrupt status lines while one transaction is in flight. When a completion event arrives it reduces the set of raised status bits to a single 3-bit error code. Native and I2C-over-AUX transactions use different priority rules. The block then reports the completion with a one-cycle pulse and says whether the requester is to be answered with ACK or DEFER. If no event arrives, a timeout counter ends the transaction.

Across transactions it keeps a counter of consecutive native failures and raises a reconfiguration request on every `RETRY_LIMIT`-th one. After any failed transaction it holds off new launches for a programmable number of cycles. The requester launches a transaction with `start` while `ready` is high and gives the mode on `isNative` in that same cycle.

Top module: `aux_status_classifier`

## Requirements
- R1: While no transaction is busy, the status inputs are ignored: no completion pulse is produced and `errCode`, `replyDefer` and `busy` keep their values.
- R2: In native mode the base code is NONE(0) when done is set, else ADDR(1) when wrong-address is set, else TOUT(2) when timeout is set. After that a set NACK/DEFER bit overrides the code to NACK(3), and a set PHY-error bit overrides any code to PHY(6).
- R3: In I2C mode with done set, the code is NACK(3) if I2C-NACK or I2C-DEFER is set and NONE(0) otherwise. All other bits are disregarded in this case, including PHY error.
- R4: In I2C mode without done, the base code is ADDR(1), else TOUT(2). Overrides then apply in this order, each later one winning: NACK/DEFER gives NACK_DEFER(5), I2C-NACK gives NACK(3), I2C-DEFER gives DEFER(4), PHY error gives PHY(6).
- R5: `irqClear` pulses for one cycle, together with `cmplValid`, exactly when a completion is classified as PHY.
- R6: If no completion event is seen within `TIMEOUT_CYCLES` cycles of launch, the transaction completes with code TOUT(2) and `cmplValid` is raised `TIMEOUT_CYCLES` cycles after the launch edge.
- R7: `cmplValid` pulses for one cycle, in the cycle after the edge that sampled the event. Together with the pulse, `errCode` shows the code and `replyDefer` is 0 (ACK) for NONE and 1 (DEFER) for any other code. Both values are held until the next completion.
- R8: Each native completion with a code other than NONE advances a failure counter. The completion that brings it to `RETRY_LIMIT` pulses `reconfigReq` and restarts the count. Any NONE completion clears the counter, and I2C failures leave it unchanged.
- R9: After a failing completion, `ready` stays low for `GAP_CYCLES` cycles and `start` is ignored during that time. After a successful completion `ready` returns at once.
- R10: In native mode a completion event is raised only by done, wrong-address, timeout, NACK/DEFER or PHY error. The I2C-NACK and I2C-DEFER bits alone leave the transaction busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a transaction (taken only while ready) |
| isNative | input | 1 | Mode of the launched transaction: 1 native, 0 I2C |
| stDone | input | 1 | Status: transaction done |
| stWrongAddr | input | 1 | Status: wrong address |
| stTimeout | input | 1 | Status: controller-side timeout |
| stNackDefer | input | 1 | Status: NACK or DEFER seen on the channel |
| stI2cNack | input | 1 | Status: I2C NACK |
| stI2cDefer | input | 1 | Status: I2C DEFER |
| stPhyErr | input | 1 | Status: physical-layer error |
| ready | output | 1 | A launch would be accepted |
| busy | output | 1 | A transaction is in flight |
| cmplValid | output | 1 | One-cycle completion pulse |
| errCode | output | 3 | Classified error code (held) |
| replyDefer | output | 1 | 0 = ACK reply, 1 = DEFER reply (held) |
| irqClear | output | 1 | Pulse requesting the controller status to be cleared |
| reconfigReq | output | 1 | Pulse requesting a controller reconfiguration |

## Verification
The bench builds the block with `TIMEOUT_CYCLES` = 40, `GAP_CYCLES` = 12 and `RETRY_LIMIT` = 5. With the short timeout, expiry can be checked on the exact cycle before and at completion. With the short gap, both the last blocked cycle and the first ready cycle can be checked, as well as a launch attempted mid-gap. The default retry limit keeps the fifth-failure reconfiguration and its interplay with I2C failures and successes in reach within a few dozen transactions.

// File: rtl/auxsc_pkg.sv
package auxsc_pkg;

  typedef enum logic [2:0] {
    ERR_NONE       = 3'd0,
    ERR_ADDR       = 3'd1,
    ERR_TOUT       = 3'd2,
    ERR_NACK       = 3'd3,
    ERR_DEFER      = 3'd4,
    ERR_NACK_DEFER = 3'd5,
    ERR_PHY        = 3'd6
  } errCodeT;

  typedef struct packed {
    logic done;
    logic wrongAddr;
    logic tmo;
    logic nackDefer;
    logic i2cNack;
    logic i2cDefer;
    logic phyErr;
  } statusT;

  // strobes from control to datapath
  typedef struct packed {
    logic launch;
    logic finishEvt;
    logic finishTmo;
  } strobeT;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_GAP  = 2'd2
  } ctrlStateT;

endpackage

// File: rtl/auxsc_datapath.sv
module auxsc_datapath
  import auxsc_pkg::*;
#(
  parameter int RETRY_LIMIT = 5
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobeT  stb,
  input  logic    isNative,
  input  statusT  stat,
  output logic    evtSeen,
  output logic    evtFail,
  output errCodeT errCode,
  output logic    replyDefer,
  output logic    cmplValid,
  output logic    irqClear,
  output logic    reconfigReq
);

  localparam int RW = $clog2(RETRY_LIMIT + 1);
  localparam logic [RW-1:0] RETRY_LAST = RW'(RETRY_LIMIT - 1);

  logic          nativeQ;
  logic [RW-1:0] retryCnt;
  errCodeT       evtCode;
  errCodeT       finalCode;
  logic          finishAny;

  // classification of the present status word
  always_comb begin
    evtCode = ERR_NONE;
    if (nativeQ) begin
      if (stat.done)           evtCode = ERR_NONE;
      else if (stat.wrongAddr) evtCode = ERR_ADDR;
      else if (stat.tmo)       evtCode = ERR_TOUT;
      if (stat.nackDefer)      evtCode = ERR_NACK;
      if (stat.phyErr)         evtCode = ERR_PHY;
    end else if (stat.done) begin
      evtCode = (stat.i2cNack || stat.i2cDefer) ? ERR_NACK : ERR_NONE;
    end else begin
      if (stat.wrongAddr)      evtCode = ERR_ADDR;
      else if (stat.tmo)       evtCode = ERR_TOUT;
      if (stat.nackDefer)      evtCode = ERR_NACK_DEFER;
      if (stat.i2cNack)        evtCode = ERR_NACK;
      if (stat.i2cDefer)       evtCode = ERR_DEFER;
      if (stat.phyErr)         evtCode = ERR_PHY;
    end
  end

  always_comb begin
    if (nativeQ)
      evtSeen = stat.done || stat.wrongAddr || stat.tmo || stat.nackDefer || stat.phyErr;
    else
      evtSeen = |stat;
  end

  assign evtFail   = (evtCode != ERR_NONE);
  assign finishAny = stb.finishEvt || stb.finishTmo;
  assign finalCode = stb.finishTmo ? ERR_TOUT : evtCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nativeQ     <= 1'b0;
      retryCnt    <= '0;
      errCode     <= ERR_NONE;
      replyDefer  <= 1'b0;
      cmplValid   <= 1'b0;
      irqClear    <= 1'b0;
      reconfigReq <= 1'b0;
    end else begin
      cmplValid   <= finishAny;
      irqClear    <= stb.finishEvt && (evtCode == ERR_PHY);
      reconfigReq <= 1'b0;
      if (stb.launch) nativeQ <= isNative;
      if (finishAny) begin
        errCode    <= finalCode;
        replyDefer <= (finalCode != ERR_NONE);
        if (finalCode == ERR_NONE) begin
          retryCnt <= '0;
        end else if (nativeQ) begin
          if (retryCnt == RETRY_LAST) begin
            retryCnt    <= '0;
            reconfigReq <= 1'b1;
          end else begin
            retryCnt <= retryCnt + 1'b1;
          end
        end
      end
    end
  end

  assert_reply_matches_code_R7: assert property (@(posedge clk) disable iff (!rstN)
    cmplValid |-> (replyDefer == (errCode != ERR_NONE)));

  assert_irqclr_only_phy_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqClear |-> (cmplValid && errCode == ERR_PHY));

  assert_reconfig_native_fail_R8: assert property (@(posedge clk) disable iff (!rstN)
    reconfigReq |-> (cmplValid && replyDefer && nativeQ));

  assert_retry_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    retryCnt <= RETRY_LAST);

endmodule

// File: rtl/auxsc_ctrl.sv
module auxsc_ctrl
  import auxsc_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 25_000_000,
  parameter int GAP_CYCLES     = 40_000
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   evtSeen,
  input  logic   evtFail,
  output strobeT stb,
  output logic   ready,
  output logic   busy
);

  localparam int  TMO_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam int  GAP_W = $clog2(GAP_CYCLES + 2);
  localparam bit  GAP_ON = (GAP_CYCLES > 0);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TIMEOUT_CYCLES - 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_ON ? GAP_CYCLES - 1 : 0);

  ctrlStateT        state;
  logic [TMO_W-1:0] tmoCnt;
  logic             inBusy;
  logic             failNow;
  logic             gapDone;

  assign inBusy        = (state == ST_BUSY);
  assign busy          = inBusy;
  assign ready         = (state == ST_IDLE);
  assign stb.launch    = ready && start;
  assign stb.finishEvt = inBusy && evtSeen;
  assign stb.finishTmo = inBusy && !evtSeen && (tmoCnt == TMO_LAST);
  assign failNow       = stb.finishTmo || (stb.finishEvt && evtFail);

  generate
    if (GAP_ON) begin : g_gap
      logic [GAP_W-1:0] gapCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 gapCnt <= '0;
        else if (state != ST_GAP)  gapCnt <= '0;
        else                       gapCnt <= gapCnt + 1'b1;
      end
      assign gapDone = (state == ST_GAP) && (gapCnt == GAP_LAST);
    end else begin : g_nogap
      assign gapDone = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      tmoCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (stb.launch) begin
          state  <= ST_BUSY;
          tmoCnt <= '0;
        end
        ST_BUSY: begin
          if (stb.finishEvt || stb.finishTmo)
            state <= (failNow && GAP_ON) ? ST_GAP : ST_IDLE;
          else
            tmoCnt <= tmoCnt + 1'b1;
        end
        ST_GAP:  if (gapDone) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  assert_gap_after_fail_R9: assert property (@(posedge clk) disable iff (!rstN)
    (failNow && GAP_ON) |=> !ready);

  assert_tmo_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    inBusy |-> (tmoCnt <= TMO_LAST));

  assert_strobe_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));

endmodule

// File: rtl/aux_status_classifier.sv
module aux_status_classifier
  import auxsc_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 25_000_000,
  parameter int GAP_CYCLES     = 40_000,
  parameter int RETRY_LIMIT    = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       isNative,
  input  logic       stDone,
  input  logic       stWrongAddr,
  input  logic       stTimeout,
  input  logic       stNackDefer,
  input  logic       stI2cNack,
  input  logic       stI2cDefer,
  input  logic       stPhyErr,
  output logic       ready,
  output logic       busy,
  output logic       cmplValid,
  output logic [2:0] errCode,
  output logic       replyDefer,
  output logic       irqClear,
  output logic       reconfigReq
);

  statusT  stat;
  strobeT  stb;
  logic    evtSeen;
  logic    evtFail;
  errCodeT codeQ;

  assign stat = '{done: stDone, wrongAddr: stWrongAddr, tmo: stTimeout,
                  nackDefer: stNackDefer, i2cNack: stI2cNack,
                  i2cDefer: stI2cDefer, phyErr: stPhyErr};

  auxsc_ctrl #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .GAP_CYCLES    (GAP_CYCLES)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .evtSeen(evtSeen),
    .evtFail(evtFail),
    .stb    (stb),
    .ready  (ready),
    .busy   (busy)
  );

  auxsc_datapath #(
    .RETRY_LIMIT(RETRY_LIMIT)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .isNative   (isNative),
    .stat       (stat),
    .evtSeen    (evtSeen),
    .evtFail    (evtFail),
    .errCode    (codeQ),
    .replyDefer (replyDefer),
    .cmplValid  (cmplValid),
    .irqClear   (irqClear),
    .reconfigReq(reconfigReq)
  );

  assign errCode = codeQ;

  assert_cmpl_needs_busy_R1: assert property (@(posedge clk) disable iff (!rstN)
    cmplValid |-> $past(busy));

  assert_code_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    !cmplValid |-> $stable(errCode));

endmodule

// File: tb/tb_aux_status_classifier.sv
module tb_aux_status_classifier;

  localparam int CLK_PERIOD = 10;
  localparam int TMO   = 40;
  localparam int GAP   = 12;
  localparam int RLIM  = 5;

  // status vector order used by the bench: {done, addr, tmo, nackDef, i2cNack, i2cDefer, phy}
  localparam logic [6:0] B_DONE = 7'b1000000;
  localparam logic [6:0] B_ADDR = 7'b0100000;
  localparam logic [6:0] B_TMO  = 7'b0010000;
  localparam logic [6:0] B_ND   = 7'b0001000;
  localparam logic [6:0] B_IN   = 7'b0000100;
  localparam logic [6:0] B_ID   = 7'b0000010;
  localparam logic [6:0] B_PHY  = 7'b0000001;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic isNative = 1'b0;
  logic [6:0] bits = '0;
  logic ready, busy, cmplValid, replyDefer, irqClear, reconfigReq;
  logic [2:0] errCode;

  int checks = 0;
  int failures = 0;
  int modelRetry = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aux_status_classifier #(
    .TIMEOUT_CYCLES(TMO),
    .GAP_CYCLES    (GAP),
    .RETRY_LIMIT   (RLIM)
  ) dut (
    .clk(clk), .rstN(rstN), .start(start), .isNative(isNative),
    .stDone(bits[6]), .stWrongAddr(bits[5]), .stTimeout(bits[4]),
    .stNackDefer(bits[3]), .stI2cNack(bits[2]), .stI2cDefer(bits[1]),
    .stPhyErr(bits[0]),
    .ready(ready), .busy(busy), .cmplValid(cmplValid), .errCode(errCode),
    .replyDefer(replyDefer), .irqClear(irqClear), .reconfigReq(reconfigReq)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int expCode(bit native, logic [6:0] b);
    int c = 0;
    if (native) begin
      if (b[6]) c = 0; else if (b[5]) c = 1; else if (b[4]) c = 2;
      if (b[3]) c = 3;
      if (b[0]) c = 6;
    end else if (b[6]) begin
      c = (b[2] || b[1]) ? 3 : 0;
    end else begin
      if (b[5]) c = 1; else if (b[4]) c = 2;
      if (b[3]) c = 5;
      if (b[2]) c = 3;
      if (b[1]) c = 4;
      if (b[0]) c = 6;
    end
    return c;
  endfunction

  // returns expected reconfigReq and updates the retry model
  function automatic bit modelFinish(bit native, int code);
    bit rq = 1'b0;
    if (code == 0) modelRetry = 0;
    else if (native) begin
      if (modelRetry == RLIM - 1) begin modelRetry = 0; rq = 1'b1; end
      else modelRetry++;
    end
    return rq;
  endfunction

  task automatic waitReady();
    while (!ready) @(negedge clk);
  endtask

  task automatic launch(bit native);
    waitReady();
    start = 1'b1; isNative = native;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runEvt(string req, bit native, logic [6:0] b);
    int ec;
    bit rq;
    ec = expCode(native, b);
    launch(native);
    bits = b;
    @(negedge clk);
    rq = modelFinish(native, ec);
    check("R7", "cmplValid", int'(cmplValid), 1);
    check(req, "errCode", int'(errCode), ec);
    check("R7", "replyDefer", int'(replyDefer), (ec != 0) ? 1 : 0);
    check("R5", "irqClear", int'(irqClear), (ec == 6) ? 1 : 0);
    check("R8", "reconfigReq", int'(reconfigReq), int'(rq));
    bits = '0;
    @(negedge clk);
    check("R7", "cmplValid pulse end", int'(cmplValid), 0);
    check(req, "errCode held", int'(errCode), ec);
  endtask

  task automatic testReset();
    check("R7", "reset cmplValid", int'(cmplValid), 0);
    check("R7", "reset errCode", int'(errCode), 0);
    check("R9", "reset ready", int'(ready), 1);
    check("R1", "reset busy", int'(busy), 0);
    check("R8", "reset reconfigReq", int'(reconfigReq), 0);
  endtask

  task automatic testNative();
    runEvt("R2", 1, B_DONE);
    runEvt("R2", 1, B_ADDR);
    runEvt("R2", 1, B_TMO);
    runEvt("R2", 1, B_DONE | B_ADDR);
    runEvt("R2", 1, B_ADDR | B_TMO);
    runEvt("R2", 1, B_ND);
    runEvt("R2", 1, B_DONE | B_ND);
    runEvt("R2", 1, B_ADDR | B_PHY);
    runEvt("R2", 1, B_DONE | B_ND | B_PHY);
  endtask

  task automatic testI2cDone();
    runEvt("R3", 0, B_DONE);
    runEvt("R3", 0, B_DONE | B_IN);
    runEvt("R3", 0, B_DONE | B_ID);
    runEvt("R3", 0, B_DONE | B_PHY);
    runEvt("R3", 0, B_DONE | B_ADDR | B_ND);
  endtask

  task automatic testI2cNoDone();
    runEvt("R4", 0, B_ADDR);
    runEvt("R4", 0, B_TMO);
    runEvt("R4", 0, B_ADDR | B_TMO);
    runEvt("R4", 0, B_ND);
    runEvt("R4", 0, B_ADDR | B_ND);
    runEvt("R4", 0, B_ND | B_IN);
    runEvt("R4", 0, B_IN | B_ID);
    runEvt("R4", 0, B_ND | B_IN | B_ID);
    runEvt("R4", 0, B_ID | B_PHY);
  endtask

  task automatic testIdleIgnored();
    int held;
    waitReady();
    held = int'(errCode);
    bits = B_ADDR | B_PHY | B_ND;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1", "idle cmplValid", int'(cmplValid), 0);
      check("R1", "idle irqClear", int'(irqClear), 0);
    end
    bits = '0;
    check("R1", "idle errCode", int'(errCode), held);
    check("R1", "idle busy", int'(busy), 0);
  endtask

  task automatic testNativeIgnoresI2cBits();
    launch(1);
    bits = B_IN | B_ID;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R10", "native i2c-only cmplValid", int'(cmplValid), 0);
      check("R10", "native i2c-only busy", int'(busy), 1);
    end
    bits = B_DONE;
    @(negedge clk);
    void'(modelFinish(1, 0));
    check("R10", "native done after i2c bits", int'(cmplValid), 1);
    check("R10", "native done code", int'(errCode), 0);
    bits = '0;
    @(negedge clk);
  endtask

  task automatic testTimeout();
    bit rq;
    launch(1);
    repeat (TMO - 1) @(negedge clk);
    check("R6", "busy before expiry", int'(busy), 1);
    check("R6", "no cmpl before expiry", int'(cmplValid), 0);
    @(negedge clk);
    rq = modelFinish(1, 2);
    check("R6", "cmpl at expiry", int'(cmplValid), 1);
    check("R6", "timeout code", int'(errCode), 2);
    check("R7", "timeout replyDefer", int'(replyDefer), 1);
    check("R8", "timeout reconfigReq", int'(reconfigReq), int'(rq));
    @(negedge clk);
  endtask

  task automatic testGap();
    launch(0);
    bits = B_ADDR;
    @(negedge clk);
    bits = '0;
    void'(modelFinish(0, 1));
    check("R9", "ready right after fail", int'(ready), 0);
    start = 1'b1; isNative = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R9", "start ignored in gap", int'(busy), 0);
    repeat (GAP - 2) @(negedge clk);
    check("R9", "last gap cycle", int'(ready), 0);
    @(negedge clk);
    check("R9", "ready after gap", int'(ready), 1);
    runEvt("R9", 0, B_DONE);
    check("R9", "ready at once after success", int'(ready), 1);
  endtask

  task automatic testRetry();
    runEvt("R8", 1, B_DONE);
    for (int i = 0; i < 4; i++) runEvt("R8", 1, B_ADDR);
    runEvt("R8", 0, B_TMO);
    runEvt("R8", 1, B_ND);
    for (int i = 0; i < 3; i++) runEvt("R8", 1, B_PHY);
    runEvt("R8", 0, B_DONE);
    for (int i = 0; i < 5; i++) runEvt("R8", 1, B_TMO);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNative();
    testI2cDone();
    testI2cNoDone();
    testIdleIgnored();
    testNativeIgnoresI2cBits();
    testTimeout();
    testGap();
    testRetry();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule